// File: doc/BRIEF.md
# Burst Concurrency Arbiter with Capture Quiet Window

This block decides when each of four bursty current consumers may run: an LED pulse train, an analog capture window, a radio transmit event and a non-volatile memory write. Each consumer raises a request, waits for its grant, runs, and pulses done. The arbiter keeps the supply peaks of chosen consumer pairs from stacking. A 6-bit exclusion mask sets which pairs may not run together, and any bit can be cleared so that the pair may overlap during test.

Around every capture the arbiter holds a radio-quiet window. A radio grant is not given while a capture is pending or running, nor for a set tail time after the capture ends. Radio grants are also spaced by a minimum gap, so that transmit happens in sparse batched bursts and not as a stream of small transfers. Every grant is bounded by a per-consumer maximum length. A grant that runs past that length is revoked and counted. Requests that had to wait are counted for each consumer. Overlaps reported by the consumers' own activity lines are counted as violations, so that none of these events passes unseen.

Top module: `burst_arbiter`

## Requirements
- R1: After reset all grants are low and the deferral, timeout and violation counters read zero.
- R2: A request from an idle consumer that conflicts with nothing is granted in the cycle after it is first sampled. Only the requesting consumer's grant rises.
- R3: Consumer indices are LED=0, capture=1, radio=2, write=3. Mask bits are bit0 LED/capture, bit1 LED/radio, bit2 LED/write, bit3 capture/radio, bit4 capture/write and bit5 radio/write, with default 6'b111110. No new grant is given to a consumer while a consumer it is excluded from holds a grant.
- R4: Capture and LED rank highest (capture first), then radio, then write. A consumer is not granted while a higher-ranked consumer that it is excluded from has a request pending.
- R5: A deferred write request stays pending and is granted once no excluded consumer holds or is being given a grant.
- R6: A grant stays high until the consumer pulses done, and it is low in the cycle after done.
- R7: A grant held without done is revoked after exactly MAX_LEN cycles of that consumer (LED default 32), and the timeout counter increments by one.
- R8: With mask bit3 set, radio is not granted while a capture is requested or granted. The first radio grant rises QUIET_TAIL+1 cycles (default 5) after the capture grant falls.
- R9: After a radio grant ends, the next radio grant rises no sooner than RF_GAP+1 cycles later (default 9).
- R10: Each consumer's deferral counter, at defer_cnt_o[c*CW +: CW], increments once for each request that could not be granted in its first sampled cycle.
- R11: The violation counter increments once at the start of each interval in which act_i shows an excluded pair active together or a consumer active without a grant.
- R12: With the exclusion mask at zero, radio and write requests made in the same cycle are granted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| excl_mask_i | input | 6 | Pairwise exclusion mask, one bit per consumer pair |
| req_i | input | 4 | Burst request per consumer |
| done_i | input | 4 | One-cycle done pulse per consumer |
| act_i | input | 4 | Consumer reports that it is actually drawing burst current |
| gnt_o | output | 4 | Grant per consumer |
| defer_cnt_o | output | 4*CW | Saturating deferral counter per consumer |
| tmo_cnt_o | output | CW | Saturating count of revoked grants |
| viol_cnt_o | output | CW | Saturating count of overlap violation onsets |

## Verification
The assertions check on every cycle that no new grant rises beside an excluded partner and that no grant rises without a request. They also check that no grant outlives its maximum length, that the radio grant keeps the quiet tail after a capture, and that the counters never step backwards. Priority order, pending writes that are served later, the exact grant latencies, the quiet and gap durations and the exact counter values can only be shown by the bench's directed scenarios. The same holds for the violation onset counting and for relaxing the mask.

// File: rtl/burst_arb_pkg.sv
package burst_arb_pkg;
  localparam int unsigned NUM_CONS  = 4;
  localparam int unsigned NUM_PAIRS = 6;

  localparam int unsigned C_LED = 0;
  localparam int unsigned C_CAP = 1;
  localparam int unsigned C_RF  = 2;
  localparam int unsigned C_NVM = 3;

  // grant evaluation order: capture, LED, radio, write
  localparam int unsigned ORDER [NUM_CONS] = '{C_CAP, C_LED, C_RF, C_NVM};

  function automatic int unsigned rank_of(int unsigned c);
    int unsigned r;
    r = 0;
    for (int unsigned k = 0; k < NUM_CONS; k++) begin
      if (ORDER[k] == c) r = k;
    end
    return r;
  endfunction

  function automatic int unsigned pair_idx(int unsigned a, int unsigned b);
    int unsigned lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    if (lo == 0) return hi - 1;
    else if (lo == 1) return hi + 1;
    else return 5;
  endfunction

  function automatic logic excluded(logic [NUM_PAIRS-1:0] m, int unsigned a, int unsigned b);
    if (a == b) return 1'b0;
    return m[pair_idx(a, b)];
  endfunction
endpackage

// File: rtl/burst_slot.sv
module burst_slot #(
  parameter int unsigned MAX_LEN = 32,
  parameter int unsigned CW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          set_i,
  input  logic          done_i,
  output logic          active_o,
  output logic          end_o,
  output logic          expire_o,
  output logic [CW-1:0] defer_cnt_o
);
  localparam int unsigned TW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [TW-1:0] tmr_q;
  logic          active_q;
  logic          wait_q;
  logic [CW-1:0] dcnt_q;

  assign expire_o    = active_q & ~done_i & (tmr_q == TW'(MAX_LEN - 1));
  assign end_o       = active_q & (done_i | expire_o);
  assign active_o    = active_q;
  assign defer_cnt_o = dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      tmr_q    <= '0;
    end else if (set_i) begin
      active_q <= 1'b1;
      tmr_q    <= '0;
    end else if (end_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  // one deferral event per request that misses its first cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      dcnt_q <= '0;
    end else if (set_i || !req_i) begin
      wait_q <= 1'b0;
    end else if (!active_q && !wait_q) begin
      wait_q <= 1'b1;
      if (dcnt_q != '1) dcnt_q <= dcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_window.sv
module burst_window #(
  parameter int unsigned QUIET_TAIL = 4,
  parameter int unsigned RF_GAP     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic quiet_en_i,
  input  logic cap_req_i,
  input  logic cap_active_i,
  input  logic cap_end_i,
  input  logic rf_end_i,
  output logic rf_block_o
);
  localparam int unsigned QW = (QUIET_TAIL < 1) ? 1 : $clog2(QUIET_TAIL + 1);
  localparam int unsigned GW = (RF_GAP < 1) ? 1 : $clog2(RF_GAP + 1);

  logic [QW-1:0] quiet_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= '0;
      gap_q   <= '0;
    end else begin
      if (cap_end_i) quiet_q <= QW'(QUIET_TAIL);
      else if (quiet_q != '0) quiet_q <= quiet_q - 1'b1;
      if (rf_end_i) gap_q <= GW'(RF_GAP);
      else if (gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign rf_block_o = (quiet_en_i & (cap_req_i | cap_active_i | (quiet_q != '0)))
                    | (gap_q != '0);
endmodule

// File: rtl/burst_grant.sv
module burst_grant
  import burst_arb_pkg::*;
(
  input  logic [NUM_PAIRS-1:0] mask_i,
  input  logic [NUM_CONS-1:0]  req_i,
  input  logic [NUM_CONS-1:0]  active_i,
  input  logic                 rf_block_i,
  output logic [NUM_CONS-1:0]  set_o
);
  logic [NUM_CONS-1:0] claimed;

  always_comb begin
    set_o   = '0;
    claimed = active_i;
    for (int unsigned r = 0; r < NUM_CONS; r++) begin
      int unsigned c;
      logic ok;
      c  = ORDER[r];
      ok = req_i[c] & ~active_i[c];
      if (c == C_RF && rf_block_i) ok = 1'b0;
      for (int unsigned j = 0; j < NUM_CONS; j++) begin
        if (excluded(mask_i, c, j) &&
            (claimed[j] || (rank_of(j) < r && req_i[j]))) ok = 1'b0;
      end
      set_o[c] = ok;
      if (ok) claimed[c] = 1'b1;
    end
  end
endmodule

// File: rtl/burst_viol_mon.sv
module burst_viol_mon
  import burst_arb_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] mask_i,
  input  logic [NUM_CONS-1:0]  act_i,
  input  logic [NUM_CONS-1:0]  gnt_i,
  output logic [CW-1:0]        viol_cnt_o
);
  logic          cond;
  logic          cond_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    cond = |(act_i & ~gnt_i);
    for (int unsigned a = 0; a < NUM_CONS; a++) begin
      for (int unsigned b = a + 1; b < NUM_CONS; b++) begin
        if (excluded(mask_i, a, b) && act_i[a] && act_i[b]) cond = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= cond;
      if (cond && !cond_q && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign viol_cnt_o = cnt_q;
endmodule

// File: rtl/burst_arbiter.sv
module burst_arbiter
  import burst_arb_pkg::*;
#(
  parameter int unsigned LED_MAX_LEN = 32,
  parameter int unsigned CAP_MAX_LEN = 64,
  parameter int unsigned RF_MAX_LEN  = 48,
  parameter int unsigned NVM_MAX_LEN = 128,
  parameter int unsigned QUIET_TAIL  = 4,
  parameter int unsigned RF_GAP      = 8,
  parameter int unsigned CW          = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_PAIRS-1:0]   excl_mask_i,
  input  logic [NUM_CONS-1:0]    req_i,
  input  logic [NUM_CONS-1:0]    done_i,
  input  logic [NUM_CONS-1:0]    act_i,
  output logic [NUM_CONS-1:0]    gnt_o,
  output logic [NUM_CONS*CW-1:0] defer_cnt_o,
  output logic [CW-1:0]          tmo_cnt_o,
  output logic [CW-1:0]          viol_cnt_o
);
  localparam int unsigned MAXL [NUM_CONS] = '{LED_MAX_LEN, CAP_MAX_LEN, RF_MAX_LEN, NVM_MAX_LEN};
  localparam int unsigned IW = $clog2(NUM_CONS + 1);

  logic [NUM_CONS-1:0] active, set, ends, expire;
  logic                rf_block;
  logic [IW-1:0]       tmo_inc;
  logic [CW:0]         tmo_sum;
  logic [CW-1:0]       tmo_q;

  for (genvar g = 0; g < NUM_CONS; g++) begin : g_slot
    burst_slot #(.MAX_LEN(MAXL[g]), .CW(CW)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i[g]),
      .set_i       (set[g]),
      .done_i      (done_i[g]),
      .active_o    (active[g]),
      .end_o       (ends[g]),
      .expire_o    (expire[g]),
      .defer_cnt_o (defer_cnt_o[g*CW +: CW])
    );
  end

  burst_window #(.QUIET_TAIL(QUIET_TAIL), .RF_GAP(RF_GAP)) u_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .quiet_en_i   (excl_mask_i[pair_idx(C_CAP, C_RF)]),
    .cap_req_i    (req_i[C_CAP]),
    .cap_active_i (active[C_CAP]),
    .cap_end_i    (ends[C_CAP]),
    .rf_end_i     (ends[C_RF]),
    .rf_block_o   (rf_block)
  );

  burst_grant u_grant (
    .mask_i     (excl_mask_i),
    .req_i      (req_i),
    .active_i   (active),
    .rf_block_i (rf_block),
    .set_o      (set)
  );

  burst_viol_mon #(.CW(CW)) u_viol (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_i     (excl_mask_i),
    .act_i      (act_i),
    .gnt_i      (active),
    .viol_cnt_o (viol_cnt_o)
  );

  assign tmo_inc = IW'($countones(expire));
  assign tmo_sum = {1'b0, tmo_q} + (CW+1)'(tmo_inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= '0;
    else if (tmo_sum[CW]) tmo_q <= '1;
    else tmo_q <= tmo_sum[CW-1:0];
  end

  assign tmo_cnt_o = tmo_q;
  assign gnt_o     = active;
endmodule

// File: rtl/burst_arbiter_chk.sv
module burst_arbiter_chk
  import burst_arb_pkg::*;
#(
  parameter int unsigned LED_MAX_LEN = 32,
  parameter int unsigned CAP_MAX_LEN = 64,
  parameter int unsigned RF_MAX_LEN  = 48,
  parameter int unsigned NVM_MAX_LEN = 128,
  parameter int unsigned QUIET_TAIL  = 4,
  parameter int unsigned RF_GAP      = 8,
  parameter int unsigned CW          = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_PAIRS-1:0]   excl_mask_i,
  input logic [NUM_CONS-1:0]    req_i,
  input logic [NUM_CONS-1:0]    done_i,
  input logic [NUM_CONS-1:0]    act_i,
  input logic [NUM_CONS-1:0]    gnt_o,
  input logic [NUM_CONS*CW-1:0] defer_cnt_o,
  input logic [CW-1:0]          tmo_cnt_o,
  input logic [CW-1:0]          viol_cnt_o
);
  localparam int unsigned MAXL [NUM_CONS] = '{LED_MAX_LEN, CAP_MAX_LEN, RF_MAX_LEN, NVM_MAX_LEN};

  logic [15:0] since_cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_cap_q <= '1;
    else if (gnt_o[C_CAP]) since_cap_q <= '0;
    else if (since_cap_q != '1) since_cap_q <= since_cap_q + 1'b1;
  end

  AST_RF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gnt_o[C_RF]) && excl_mask_i[pair_idx(C_CAP, C_RF)]) |-> (since_cap_q > 16'(QUIET_TAIL))); // R8

  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_cnt_o >= $past(tmo_cnt_o)) && (viol_cnt_o >= $past(viol_cnt_o))); // R7

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic [15:0] len_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) len_q <= '0;
      else if (gnt_o[c]) len_q <= len_q + 1'b1;
      else len_q <= '0;
    end

    AST_GNT_MAX_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[c] |-> (len_q < 16'(MAXL[c]))); // R7

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gnt_o[c]) |-> $past(req_i[c])); // R2

    AST_GNT_DROP_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[c] && done_i[c]) |=> !gnt_o[c]); // R6

    for (genvar d = 0; d < NUM_CONS; d++) begin : g_pair
      if (c != d) begin : g_ne
        AST_NO_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ($rose(gnt_o[c]) && excluded(excl_mask_i, c, d)) |-> !gnt_o[d]); // R3
      end
    end
  end
endmodule

bind burst_arbiter burst_arbiter_chk #(
  .LED_MAX_LEN (LED_MAX_LEN),
  .CAP_MAX_LEN (CAP_MAX_LEN),
  .RF_MAX_LEN  (RF_MAX_LEN),
  .NVM_MAX_LEN (NVM_MAX_LEN),
  .QUIET_TAIL  (QUIET_TAIL),
  .RF_GAP      (RF_GAP),
  .CW          (CW)
) u_chk (.*);

// File: tb/tb_burst_arbiter.sv
module tb_burst_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;
  localparam int QUIET      = 4;
  localparam int GAP        = 8;
  localparam int LED_MAX    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    mask = 6'b111110;
  logic [3:0]    req = '0;
  logic [3:0]    done = '0;
  logic [3:0]    act = '0;
  logic [3:0]    gnt;
  logic [4*CW-1:0] dcnt;
  logic [CW-1:0] tmo;
  logic [CW-1:0] viol;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .excl_mask_i(mask), .req_i(req), .done_i(done),
    .act_i(act), .gnt_o(gnt), .defer_cnt_o(dcnt), .tmo_cnt_o(tmo), .viol_cnt_o(viol)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, a, e);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic finish_pulse(input int c);
    done[c] = 1'b1;
    req[c]  = 1'b0;
    nxt();
    done[c] = 1'b0;
  endtask

  task automatic t_reset();
    check(gnt == 4'b0000, "R1 grants", gnt, 0);
    check(dcnt == '0 && tmo == '0 && viol == '0, "R1 counters", {dcnt[15:0], tmo, viol}, 0);
  endtask

  task automatic t_single();
    req[3] = 1'b1;
    nxt();
    check(gnt == 4'b1000, "R2 single write grant", gnt, 4'b1000);
    for (int i = 0; i < 5; i++) nxt();
    check(gnt == 4'b1000, "R6 grant held", gnt, 4'b1000);
    finish_pulse(3);
    check(gnt == 4'b0000, "R6 grant drops after done", gnt, 0);
  endtask

  task automatic t_priority();
    req[0] = 1'b1;
    req[3] = 1'b1;
    nxt();
    check(gnt == 4'b0001, "R4 LED over write", gnt, 4'b0001);
    for (int i = 0; i < 3; i++) begin
      nxt();
      check(gnt[3] == 1'b0, "R3 write excluded while LED", gnt, 4'b0001);
    end
    finish_pulse(0);
    check(gnt == 4'b0000, "R5 gap cycle after LED done", gnt, 0);
    nxt();
    check(gnt == 4'b1000, "R5 pending write granted", gnt, 4'b1000);
    check(dcnt[3*CW +: CW] == 8'd1, "R10 write defer count", dcnt[3*CW +: CW], 1);
    finish_pulse(3);
    req[2] = 1'b1;
    req[3] = 1'b1;
    nxt();
    check(gnt == 4'b0100, "R4 radio over write", gnt, 4'b0100);
    finish_pulse(2);
    check(gnt == 4'b0000, "R5 write still waiting", gnt, 0);
    nxt();
    check(gnt == 4'b1000, "R5 write granted after radio", gnt, 4'b1000);
    finish_pulse(3);
  endtask

  task automatic t_timeout();
    int n;
    n = 0;
    req[0] = 1'b1;
    for (int i = 0; i < 200; i++) begin
      nxt();
      if (gnt[0]) n++;
      else if (n > 0) break;
    end
    req[0] = 1'b0;
    check(n == LED_MAX, "R7 revoke length", n, LED_MAX);
    check(tmo == 8'd1, "R7 timeout count", tmo, 1);
    nxt();
    check(gnt == 4'b0000, "R7 no regrant after drop", gnt, 0);
  endtask

  task automatic t_quiet_gap();
    int n;
    req[1] = 1'b1;
    nxt();
    check(gnt == 4'b0010, "R2 capture grant", gnt, 4'b0010);
    req[2] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      nxt();
      check(gnt[2] == 1'b0, "R8 radio blocked in capture", gnt, 4'b0010);
    end
    finish_pulse(1);
    n = 0;
    for (int i = 0; i < 50 && !gnt[2]; i++) begin
      nxt();
      n++;
    end
    check(n == QUIET + 1, "R8 quiet tail length", n, QUIET + 1);
    check(dcnt[2*CW +: CW] == 8'd1, "R10 radio defer count", dcnt[2*CW +: CW], 1);
    nxt();
    finish_pulse(2);
    check(gnt == 4'b0000, "R9 radio released", gnt, 0);
    req[2] = 1'b1;
    n = 0;
    for (int i = 0; i < 50 && !gnt[2]; i++) begin
      nxt();
      n++;
    end
    check(n == GAP + 1, "R9 radio spacing", n, GAP + 1);
    finish_pulse(2);
  endtask

  task automatic t_mask();
    for (int i = 0; i < 12; i++) nxt();
    mask = 6'b000000;
    req[2] = 1'b1;
    req[3] = 1'b1;
    nxt();
    check(gnt == 4'b1100, "R12 relaxed pair together", gnt, 4'b1100);
    done[2] = 1'b1;
    finish_pulse(3);
    done[2] = 1'b0;
    req[2] = 1'b0;
    mask = 6'b111110;
    nxt();
    check(gnt == 4'b0000, "R6 both released", gnt, 0);
  endtask

  task automatic t_viol();
    req[3] = 1'b1;
    nxt();
    act[3] = 1'b1;
    for (int i = 0; i < 3; i++) nxt();
    check(viol == 8'd0, "R11 granted activity is clean", viol, 0);
    act[3] = 1'b0;
    finish_pulse(3);
    act = 4'b0101;
    nxt();
    check(viol == 8'd1, "R11 excluded overlap counted", viol, 1);
    nxt();
    nxt();
    check(viol == 8'd1, "R11 onset counted once", viol, 1);
    act = 4'b0000;
    nxt();
    act = 4'b1000;
    nxt();
    check(viol == 8'd2, "R11 ungranted activity counted", viol, 2);
    act = 4'b0000;
    nxt();
  endtask

  task automatic t_final();
    check(dcnt[0*CW +: CW] == 8'd0, "R10 LED defer final", dcnt[0*CW +: CW], 0);
    check(dcnt[1*CW +: CW] == 8'd0, "R10 capture defer final", dcnt[1*CW +: CW], 0);
    check(dcnt[2*CW +: CW] == 8'd2, "R10 radio defer final", dcnt[2*CW +: CW], 2);
    check(dcnt[3*CW +: CW] == 8'd2, "R10 write defer final", dcnt[3*CW +: CW], 2);
    check(tmo == 8'd1, "R7 timeout final", tmo, 1);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    nxt();
    nxt();
    t_reset();
    rst_n = 1'b1;
    nxt();
    t_reset();
    t_single();
    t_priority();
    t_timeout();
    t_quiet_gap();
    t_mask();
    t_viol();
    t_final();
    report();
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    report();
  end
endmodule